// File: doc/BRIEF.md
# Symmetric Pre-Adder Multiply-Accumulate Tap Engine

This block is the arithmetic core of a four-tap symmetric FIR stage. Each tap receives one sample from the forward delay path and one from the reverse delay path. A small ALU folds the pair into one value, and that value is multiplied by the tap's coefficient. Folding the pair first lets four multipliers serve eight symmetric taps. The four products are summed into a 28-bit accumulator. A single accumulate-enable control decides whether a cycle continues the running total or closes it and starts a new one.

The ALU operation is not a separate input. It is decoded from two operand-zeroing controls together with the symmetry mode. This gives sum, difference, pass-forward, negate-forward, pass-reverse and zero. Coefficients come from an external store of 32 sets. The block registers the requested set number every clock and presents it on `coef_set`. The store returns that set's four coefficients on `coef_word` in the same cycle.

All samples, the zeroing controls, the set number and the accumulate-enable pass through one input register stage. The sum of products enters the accumulator one edge later. A closed total reaches `acc_out` one edge after that. Format and symmetry inputs are quasi-static configuration.

Top module: `symtap_engine`

## Requirements
- R1: While `rst_n` is low, `acc_out` and `coef_set` are 0, and the first edge after release leaves `acc_out` at 0.
- R2: With `fwd_zero` and `rev_zero` both low, each tap's pre-adder yields reverse+forward when `odd_sym`=0 and reverse−forward when `odd_sym`=1.
- R3: With `fwd_zero` low and `rev_zero` high, each tap yields the forward sample when `odd_sym`=0 and its negation when `odd_sym`=1.
- R4: With `fwd_zero` high and `rev_zero` low, each tap yields the reverse sample in either symmetry mode. With both high, each tap yields 0.
- R5: `data_tc`=0 treats samples as unsigned (zero-extended) and `data_tc`=1 as 10-bit two's complement. `coef_tc` selects the same two formats for coefficients, independently of `data_tc`.
- R6: `set_sel` is registered on every edge and appears on `coef_set` after that edge, so the set may change each cycle. Tap i uses `coef_word[10i+9:10i]`, and tap i's samples are `fwd_smp[10i+9:10i]` and `rev_smp[10i+9:10i]`.
- R7: Samples registered at edge k with `acc_en`=1 add their sum of products to the running total at edge k+1, and `acc_out` does not change at edge k+1.
- R8: Samples registered at edge k with `acc_en`=0 start a fresh total at edge k+1, with zero fed back. At the same edge, `acc_out` loads the total that was closed.
- R9: The accumulator and `acc_out` are 28-bit two's complement and wrap modulo 2^28.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fwd_smp | input | 40 | Four forward-path samples, tap i at bits 10i+9:10i |
| rev_smp | input | 40 | Four reverse-path samples, tap i at bits 10i+9:10i |
| fwd_zero | input | 1 | High forces the forward operand to zero |
| rev_zero | input | 1 | High forces the reverse operand to zero |
| odd_sym | input | 1 | 0 even-symmetric, 1 odd-symmetric |
| data_tc | input | 1 | Sample format: 0 unsigned, 1 two's complement |
| coef_tc | input | 1 | Coefficient format: 0 unsigned, 1 two's complement |
| acc_en | input | 1 | 1 continues the running total, 0 closes it |
| set_sel | input | 5 | Requested coefficient set |
| coef_set | output | 5 | Registered set number sent to the coefficient store |
| coef_word | input | 40 | Four coefficients of the set on `coef_set` |
| acc_out | output | 28 | Registered closed accumulator total |

## Verification
The bench covers every pairing of the two zeroing controls with both symmetry modes. A wrong decode would give a sum where a negation is due, or leak a zeroed operand. It drives the extreme codes 0, 511, 512 and 1023 under all four format combinations. There, a missing sign extension turns 512 into a large positive value, and a sign extension applied to unsigned data turns 1023 negative. Accumulate-enable is run in runs of different lengths and also toggled on every cycle, which exposes a total that closes one cycle early or late, or an output that moves while accumulating. A long run of full-scale unsigned products pushes the total past 2^28, where a saturating or too-narrow accumulator would read differently from the modulo value.

// File: rtl/symtap_pkg.sv
package symtap_pkg;

    typedef enum logic [2:0] {
        OP_ZERO,
        OP_SUM,
        OP_DIFF,
        OP_PASS_A,
        OP_NEG_A,
        OP_PASS_B
    } alu_op_e;

    typedef enum logic {
        ACC_DUMP,
        ACC_RUN
    } acc_phase_e;

    // Joint decode of the two operand-zeroing controls and symmetry mode.
    function automatic alu_op_e decode_op(input logic fz, input logic rz, input logic odd);
        alu_op_e op;
        case ({fz, rz})
            2'b00:   op = odd ? OP_DIFF : OP_SUM;
            2'b01:   op = odd ? OP_NEG_A : OP_PASS_A;
            2'b10:   op = OP_PASS_B;
            default: op = OP_ZERO;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/symtap_prealu.sv
module symtap_prealu
    import symtap_pkg::*;
#(
    parameter int DW = 10
) (
    input  logic [DW-1:0]        fwd_s,
    input  logic [DW-1:0]        rev_s,
    input  logic                 data_tc,
    input  alu_op_e              op,
    output logic signed [DW+1:0] pre
);

    logic signed [DW+1:0] a_x;
    logic signed [DW+1:0] b_x;

    // Two guard bits: one for format extension, one for the sum carry.
    assign a_x = data_tc ? {{2{fwd_s[DW-1]}}, fwd_s} : {2'b00, fwd_s};
    assign b_x = data_tc ? {{2{rev_s[DW-1]}}, rev_s} : {2'b00, rev_s};

    always_comb begin
        unique case (op)
            OP_SUM:    pre = b_x + a_x;
            OP_DIFF:   pre = b_x - a_x;
            OP_PASS_A: pre = a_x;
            OP_NEG_A:  pre = -a_x;
            OP_PASS_B: pre = b_x;
            default:   pre = '0;
        endcase
    end

endmodule

// File: rtl/symtap_mac.sv
module symtap_mac #(
    parameter int NTAP = 4,
    parameter int PW   = 12,
    parameter int CW   = 10,
    parameter int SW   = 25
) (
    input  logic [NTAP*PW-1:0]   pre_flat,
    input  logic [NTAP*CW-1:0]   coef_flat,
    input  logic                 coef_tc,
    output logic signed [SW-1:0] psum
);

    localparam int XW = PW + CW + 1;

    logic signed [XW-1:0] prod [NTAP];

    for (genvar gi = 0; gi < NTAP; gi++) begin : g_tap
        logic signed [PW-1:0] p_v;
        logic        [CW-1:0] c_raw;
        logic signed [CW:0]   c_x;

        assign p_v      = pre_flat[gi*PW +: PW];
        assign c_raw    = coef_flat[gi*CW +: CW];
        assign c_x      = coef_tc ? {c_raw[CW-1], c_raw} : {1'b0, c_raw};
        assign prod[gi] = XW'(p_v) * XW'(c_x);
    end

    always_comb begin
        psum = '0;
        for (int i = 0; i < NTAP; i++) begin
            psum = psum + SW'(prod[i]);
        end
    end

endmodule

// File: rtl/symtap_accum.sv
module symtap_accum
    import symtap_pkg::*;
#(
    parameter int SW = 25,
    parameter int AW = 28
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_en,
    input  logic signed [SW-1:0] psum,
    output logic [AW-1:0]        acc_out
);

    acc_phase_e           phase_q;
    logic signed [AW-1:0] acc_q;
    logic signed [AW-1:0] fb;
    logic signed [AW-1:0] out_q;

    // State register: phase of the samples now in the input stage.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= ACC_DUMP;
        end else begin
            phase_q <= acc_en ? ACC_RUN : ACC_DUMP;
        end
    end

    // Feedback: zeroed when a total is being closed.
    always_comb begin
        unique case (phase_q)
            ACC_RUN:  fb = acc_q;
            ACC_DUMP: fb = '0;
        endcase
    end

    // Outputs: running total and the held closed total.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            out_q <= '0;
        end else begin
            acc_q <= AW'(psum) + fb;
            if (phase_q == ACC_DUMP) begin
                out_q <= acc_q;
            end
        end
    end

    assign acc_out = out_q;

endmodule

// File: rtl/symtap_engine.sv
module symtap_engine
    import symtap_pkg::*;
#(
    parameter int  NTAP = 4,
    parameter int  DW   = 10,
    parameter int  CW   = 10,
    parameter int  NSET = 32,
    parameter int  AW   = 28,
    localparam int SETW = $clog2(NSET)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NTAP*DW-1:0]   fwd_smp,
    input  logic [NTAP*DW-1:0]   rev_smp,
    input  logic                 fwd_zero,
    input  logic                 rev_zero,
    input  logic                 odd_sym,
    input  logic                 data_tc,
    input  logic                 coef_tc,
    input  logic                 acc_en,
    input  logic [SETW-1:0]      set_sel,
    output logic [SETW-1:0]      coef_set,
    input  logic [NTAP*CW-1:0]   coef_word,
    output logic [AW-1:0]        acc_out
);

    localparam int PW = DW + 2;
    localparam int XW = PW + CW + 1;
    localparam int SW = XW + $clog2(NTAP);

    logic [NTAP*DW-1:0] fwd_q;
    logic [NTAP*DW-1:0] rev_q;
    logic               fz_q;
    logic               rz_q;
    logic [SETW-1:0]    set_q;
    alu_op_e            op;
    logic [NTAP*PW-1:0] pre_flat;
    logic signed [SW-1:0] psum;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fwd_q <= '0;
            rev_q <= '0;
            fz_q  <= 1'b0;
            rz_q  <= 1'b0;
            set_q <= '0;
        end else begin
            fwd_q <= fwd_smp;
            rev_q <= rev_smp;
            fz_q  <= fwd_zero;
            rz_q  <= rev_zero;
            set_q <= set_sel;
        end
    end

    assign op       = decode_op(fz_q, rz_q, odd_sym);
    assign coef_set = set_q;

    for (genvar gi = 0; gi < NTAP; gi++) begin : g_alu
        logic signed [PW-1:0] pre_g;

        symtap_prealu #(.DW(DW)) u_alu (
            .fwd_s   (fwd_q[gi*DW +: DW]),
            .rev_s   (rev_q[gi*DW +: DW]),
            .data_tc (data_tc),
            .op      (op),
            .pre     (pre_g)
        );

        assign pre_flat[gi*PW +: PW] = pre_g;
    end

    symtap_mac #(.NTAP(NTAP), .PW(PW), .CW(CW), .SW(SW)) u_mac (
        .pre_flat  (pre_flat),
        .coef_flat (coef_word),
        .coef_tc   (coef_tc),
        .psum      (psum)
    );

    symtap_accum #(.SW(SW), .AW(AW)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc_en  (acc_en),
        .psum    (psum),
        .acc_out (acc_out)
    );

endmodule

// File: rtl/symtap_chk.sv
module symtap_chk #(
    parameter int SETW = 5,
    parameter int AW   = 28
) (
    input logic            clk,
    input logic            rst_n,
    input logic            fwd_zero,
    input logic            rev_zero,
    input logic            acc_en,
    input logic [SETW-1:0] set_sel,
    input logic [SETW-1:0] coef_set,
    input logic [AW-1:0]   acc_out
);

    // Edges seen since reset release, saturating at 3.
    logic [1:0] seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen <= '0;
        end else if (seen != 2'd3) begin
            seen <= seen + 2'd1;
        end
    end

    a_r1_clear_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        (seen == 2'd1) |-> (acc_out == '0));

    a_r6_set_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (seen != 2'd0) |-> (coef_set == $past(set_sel)));

    a_r7_hold_while_running: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 2'd2 && $past(acc_en, 2)) |-> $stable(acc_out));

    a_r4_both_zero_gives_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (seen == 2'd3 && $past(fwd_zero, 3) && $past(rev_zero, 3)
         && !$past(acc_en, 3) && !$past(acc_en, 2)) |-> (acc_out == '0));

endmodule

bind symtap_engine symtap_chk #(.SETW(SETW), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fwd_zero (fwd_zero),
    .rev_zero (rev_zero),
    .acc_en   (acc_en),
    .set_sel  (set_sel),
    .coef_set (coef_set),
    .acc_out  (acc_out)
);

// File: tb/sim_symtap_engine.sv
module sim_symtap_engine;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [39:0] fwd_smp = '0;
    logic [39:0] rev_smp = '0;
    logic        fwd_zero = 1'b0;
    logic        rev_zero = 1'b0;
    logic        odd_sym = 1'b0;
    logic        data_tc = 1'b0;
    logic        coef_tc = 1'b0;
    logic        acc_en = 1'b0;
    logic [4:0]  set_sel = '0;
    logic [4:0]  coef_set;
    logic [39:0] coef_word;
    logic [27:0] acc_out;

    logic [9:0]  cmem [32][4];

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    chk_on   = 1'b0;
    string cur_tag  = "R1";

    // Reference model state
    logic [39:0]        m_f, m_r;
    logic               m_fz, m_rz, m_en;
    logic [4:0]         m_set;
    logic signed [27:0] m_acc, m_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    symtap_engine u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .fwd_smp   (fwd_smp),
        .rev_smp   (rev_smp),
        .fwd_zero  (fwd_zero),
        .rev_zero  (rev_zero),
        .odd_sym   (odd_sym),
        .data_tc   (data_tc),
        .coef_tc   (coef_tc),
        .acc_en    (acc_en),
        .set_sel   (set_sel),
        .coef_set  (coef_set),
        .coef_word (coef_word),
        .acc_out   (acc_out)
    );

    // Coefficient store answering the registered set number.
    always_comb begin
        for (int t = 0; t < 4; t++) begin
            coef_word[t*10 +: 10] = cmem[coef_set][t];
        end
    end

    function automatic longint ext10(input logic [9:0] v, input logic tc);
        return (tc && v[9]) ? longint'(v) - 1024 : longint'(v);
    endfunction

    function automatic longint model_sum();
        longint s = 0;
        for (int t = 0; t < 4; t++) begin
            longint a = m_fz ? 0 : ext10(m_f[t*10 +: 10], data_tc);
            longint b = m_rz ? 0 : ext10(m_r[t*10 +: 10], data_tc);
            longint p = odd_sym ? (b - a) : (b + a);
            s += p * ext10(cmem[m_set][t], coef_tc);
        end
        return s;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_f = '0; m_r = '0; m_fz = 0; m_rz = 0; m_en = 0; m_set = '0;
            m_acc = '0; m_out = '0;
        end else begin
            longint nacc;
            logic signed [27:0] nout;
            nout  = m_en ? m_out : m_acc;
            nacc  = model_sum() + (m_en ? longint'(m_acc) : 0);
            m_out = nout;
            m_acc = nacc[27:0];
            m_f = fwd_smp; m_r = rev_smp; m_fz = fwd_zero; m_rz = rev_zero;
            m_en = acc_en; m_set = set_sel;
        end
    end

    always @(negedge clk) begin
        if (chk_on) begin
            n_checks++;
            if (acc_out !== m_out) begin
                n_fails++;
                $display("FAIL %s acc_out actual=%0h expected=%0h", cur_tag, acc_out, m_out);
            end
            n_checks++;
            if (coef_set !== m_set) begin
                n_fails++;
                $display("FAIL %s coef_set actual=%0d expected=%0d", cur_tag, coef_set, m_set);
            end
        end
    end

    task automatic rand_samples(input bit extreme);
        logic [9:0] pick [5] = '{10'd0, 10'd1, 10'd511, 10'd512, 10'd1023};
        for (int t = 0; t < 4; t++) begin
            if (extreme) begin
                fwd_smp[t*10 +: 10] = pick[$urandom_range(0, 4)];
                rev_smp[t*10 +: 10] = pick[$urandom_range(0, 4)];
            end else begin
                fwd_smp[t*10 +: 10] = 10'($urandom_range(0, 1023));
                rev_smp[t*10 +: 10] = 10'($urandom_range(0, 1023));
            end
        end
    endtask

    task automatic run(input int n, input bit extreme);
        repeat (n) begin
            rand_samples(extreme);
            set_sel = 5'($urandom_range(0, 31));
            @(negedge clk);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        for (int s = 0; s < 32; s++) begin
            for (int t = 0; t < 4; t++) begin
                cmem[s][t] = 10'((s * 37 + t * 91 + 5) % 1024);
            end
        end
        for (int t = 0; t < 4; t++) begin
            cmem[31][t] = 10'h3FF;
            cmem[0][t]  = 10'h200;
        end

        // R1: reset state
        cur_tag = "R1";
        chk_on  = 1'b1;
        fwd_smp = '1;
        rev_smp = '1;
        set_sel = 5'd9;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: sum and difference
        cur_tag = "R2"; data_tc = 1; coef_tc = 1; odd_sym = 0;
        run(20, 0);
        odd_sym = 1;
        run(20, 0);

        // R3: pass forward and negate forward
        cur_tag = "R3"; rev_zero = 1; odd_sym = 0;
        run(15, 0);
        odd_sym = 1;
        run(15, 0);

        // R4: pass reverse in both modes, then both operands zeroed
        cur_tag = "R4"; rev_zero = 0; fwd_zero = 1; odd_sym = 0;
        run(10, 0);
        odd_sym = 1;
        run(10, 0);
        rev_zero = 1;
        run(10, 0);
        fwd_zero = 0; rev_zero = 0;

        // R5: all four format combinations with extreme codes
        cur_tag = "R5";
        for (int f = 0; f < 4; f++) begin
            data_tc = f[0];
            coef_tc = f[1];
            odd_sym = 0;
            run(12, 1);
            odd_sym = 1;
            run(12, 1);
        end

        // R6: set number changing every cycle
        cur_tag = "R6"; data_tc = 0; coef_tc = 1; odd_sym = 0;
        run(30, 0);

        // R7: accumulation runs of increasing length
        cur_tag = "R7"; data_tc = 1;
        for (int k = 1; k <= 6; k++) begin
            acc_en = 1;
            run(k, 0);
            acc_en = 0;
            run(2, 0);
        end

        // R8: accumulate-enable toggled every cycle
        cur_tag = "R8";
        for (int k = 0; k < 20; k++) begin
            acc_en = k[0];
            run(1, 0);
        end
        acc_en = 0;
        run(3, 0);

        // R9: full-scale unsigned products summed past 2^28
        cur_tag = "R9"; data_tc = 0; coef_tc = 0; odd_sym = 0;
        fwd_smp = '1; rev_smp = '1; set_sel = 5'd31;
        acc_en = 1;
        repeat (70) @(negedge clk);
        acc_en = 0;
        repeat (4) @(negedge clk);

        chk_on = 1'b0;
        summary();
        $finish;
    end

endmodule